// File: doc/BRIEF.md
# Keyboard Scan-Code Receiver

This block listens to the clock and data lines of a PS/2 keyboard, rebuilds each serial frame into an 8-bit scan code, and holds the codes in a small circular buffer until a consumer takes them. Both lines first pass through a two-flop synchronizer and a glitch filter. Bits are then taken on each falling edge of the cleaned keyboard clock. If the keyboard stays quiet for longer than a set idle window, the next edge begins a new frame, so a half-received frame cannot shift every later frame out of line.

On the consumer side the block hides the release prefix byte (0xF0). When that byte reaches the head of the buffer and another byte is queued behind it, the prefix is dropped and a sticky release flag is raised. The consumer therefore sees only make codes, each with a press or release tag. A bare prefix with nothing behind it is never offered as data. Sending to the keyboard and translating scan codes are outside this block.

Top module: `kbd_code_rx`

## Requirements
- R1: A frame is eleven falling edges of the filtered keyboard clock. The first sample (start bit) is discarded, the next eight samples form the code least significant bit first, and the complete code is then offered on codeOut with codeValid high.
- R2: The parity sample (edge 10) and the stop sample (edge 11) are not checked. A frame with wrong parity or a low stop bit still delivers its code.
- R3: The buffer has DEPTH slots and holds at most DEPTH-1 codes (15 by default). A frame that completes while the buffer is full is dropped, and the codes already stored stay unchanged.
- R4: Codes are delivered in the order their frames completed.
- R5: When the head code is 0xF0 and at least one more code is stored behind it, the 0xF0 is removed, releaseFlag is set, and the next code is presented.
- R6: codeValid is low when the buffer is empty, and also when the only stored code is 0xF0.
- R7: A read (rdStrobe high while codeValid is high) removes the presented code and clears releaseFlag. A code with no 0xF0 in front of it is presented with releaseFlag low.
- R8: If at least IDLE_US microseconds of system clock (CLK_HZ based) pass with no falling clock edge, the bit count and partial code are cleared before the next edge is taken.
- R9: A pulse on the keyboard clock line shorter than FILT_LEN system clock cycles is not seen as an edge.
- R10: After reset, codeValid and releaseFlag are low.
- R11: rdStrobe has no effect while codeValid is low.
- R12: A read and a frame completion in the same cycle both take effect. The presented code is removed and the new code is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ps2Clk | input | 1 | Keyboard clock line, idle high |
| ps2Dat | input | 1 | Keyboard data line, idle high |
| rdStrobe | input | 1 | Consumer read pulse, takes the presented code |
| codeValid | output | 1 | A make code is presented |
| codeOut | output | 8 | Presented scan code |
| releaseFlag | output | 1 | Presented code follows a release prefix |

## Verification
The two functions that can meet in one cycle are the write of a completed frame into the buffer and the consumer's read of the head code. To provoke this, one code is preloaded. A second frame is then sent while a single read pulse is placed at each offset, from 0 to 15 cycles after the last falling keyboard edge. One of these offsets lands on the write cycle. In every case the result is judged the same way: the preloaded code must be gone, the new code must be presented with the release flag low, and nothing else may remain.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int CODE_W    = 8;
  localparam int FRAME_LEN = 11;
  localparam logic [CODE_W-1:0] RELEASE_PREFIX = 8'hF0;

  typedef struct packed {
    logic              push;
    logic [CODE_W-1:0] code;
  } rxStrobe_t;
endpackage

// File: rtl/kbd_line_filter.sv
module kbd_line_filter #(
  parameter int STABLE = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(STABLE + 1);

  logic          syncA, syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncQ    <= 1'b1;
      cleanOut <= 1'b1;
      runCnt   <= '0;
    end else begin
      syncA <= rawIn;
      syncQ <= syncA;
      if (syncQ != cleanOut) begin
        if (runCnt == CW'(STABLE - 1)) begin
          cleanOut <= syncQ;
          runCnt   <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  // R9: the clean level only moves to a value the synchronizer already held
  p_filter_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cleanOut != $past(cleanOut)) |-> ($past(syncQ) == cleanOut));
endmodule

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl
  import kbd_rx_pkg::*;
#(
  parameter int FILT_LEN    = 3,
  parameter int IDLE_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ps2Clk,
  input  logic      ps2Dat,
  output rxStrobe_t strobe
);
  localparam int IW = $clog2(IDLE_CYCLES + 1);
  localparam logic [3:0] LAST_IDX = 4'(FRAME_LEN - 1);

  logic [1:0] rawLines, cleanLines;
  assign rawLines = {ps2Dat, ps2Clk};

  for (genvar g = 0; g < 2; g++) begin : gLine
    kbd_line_filter #(.STABLE(FILT_LEN)) uFilt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawLines[g]),
      .cleanOut (cleanLines[g])
    );
  end

  logic              clkPrev, fallEdge, timedOut, frameDone;
  logic [IW-1:0]     idleCnt;
  logic [3:0]        bitCnt, effCnt;
  logic [CODE_W-1:0] shiftByte, effByte, nextByte;

  assign fallEdge = clkPrev & ~cleanLines[0];
  assign timedOut = (idleCnt == IW'(IDLE_CYCLES));

  always_comb begin
    effCnt   = timedOut ? 4'd0 : bitCnt;
    effByte  = timedOut ? '0 : shiftByte;
    nextByte = effByte;
    if (effCnt >= 4'd1 && effCnt <= 4'(CODE_W))
      nextByte[3'(effCnt - 4'd1)] = cleanLines[1];
    frameDone = (effCnt == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev   <= 1'b1;
      idleCnt   <= '0;
      bitCnt    <= '0;
      shiftByte <= '0;
      strobe    <= '0;
    end else begin
      clkPrev     <= cleanLines[0];
      strobe.push <= 1'b0;
      if (fallEdge) begin
        idleCnt <= '0;
        if (frameDone) begin
          bitCnt      <= '0;
          shiftByte   <= '0;
          strobe.push <= 1'b1;
          strobe.code <= nextByte;
        end else begin
          bitCnt    <= effCnt + 4'd1;
          shiftByte <= nextByte;
        end
      end else if (!timedOut) begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  p_bitcnt_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_IDX);
  p_push_after_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> $past(fallEdge));
  p_idle_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && timedOut) |=> (bitCnt == 4'd1));
endmodule

// File: rtl/kbd_rx_dp.sv
module kbd_rx_dp
  import kbd_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              rdStrobe,
  output logic              codeValid,
  output logic [CODE_W-1:0] codeOut,
  output logic              releaseFlag
);
  localparam int AW = $clog2(DEPTH);

  logic [CODE_W-1:0] store [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr, used;
  logic              full, headIsPrefix, stripNow, takeNow, popNow, writeNow;

  assign used         = wrPtr - rdPtr;
  assign full         = (AW'(wrPtr + 1'b1) == rdPtr);
  assign codeOut      = store[rdPtr];
  assign headIsPrefix = (codeOut == RELEASE_PREFIX);
  assign codeValid    = (used != '0) && !headIsPrefix;
  assign stripNow     = headIsPrefix && (used >= AW'(2));
  assign takeNow      = rdStrobe && codeValid;
  assign popNow       = stripNow || takeNow;
  assign writeNow     = strobe.push && !full;

  always_ff @(posedge clk) begin
    if (writeNow) store[wrPtr] <= strobe.code;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      releaseFlag <= 1'b0;
    end else begin
      if (writeNow) wrPtr <= wrPtr + 1'b1;
      if (popNow)   rdPtr <= rdPtr + 1'b1;
      if (stripNow)     releaseFlag <= 1'b1;
      else if (takeNow) releaseFlag <= 1'b0;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && full) |=> (wrPtr == $past(wrPtr)));
  p_prefix_hidden_r5: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> (codeOut != RELEASE_PREFIX));
  p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr == rdPtr) |-> !codeValid);
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && codeValid) |=> !releaseFlag);
  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!codeValid && !stripNow) |=> (rdPtr == $past(rdPtr)));
endmodule

// File: rtl/kbd_code_rx.sv
module kbd_code_rx
  import kbd_rx_pkg::*;
#(
  parameter int CLK_HZ   = 200_000_000,
  parameter int IDLE_US  = 250_000,
  parameter int FILT_LEN = 3,
  parameter int DEPTH    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ps2Clk,
  input  logic       ps2Dat,
  input  logic       rdStrobe,
  output logic       codeValid,
  output logic [7:0] codeOut,
  output logic       releaseFlag
);
  localparam int IDLE_CYCLES = (CLK_HZ / 1_000_000) * IDLE_US;

  rxStrobe_t rxStrobe;

  kbd_rx_ctrl #(.FILT_LEN(FILT_LEN), .IDLE_CYCLES(IDLE_CYCLES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ps2Clk (ps2Clk),
    .ps2Dat (ps2Dat),
    .strobe (rxStrobe)
  );

  kbd_rx_dp #(.DEPTH(DEPTH)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (rxStrobe),
    .rdStrobe    (rdStrobe),
    .codeValid   (codeValid),
    .codeOut     (codeOut),
    .releaseFlag (releaseFlag)
  );
endmodule

// File: tb/test_kbd_code_rx.sv
`timescale 1ns/1ps
module test_kbd_code_rx;
  localparam int HALF = 20;
  localparam int IDLE = 300;
  localparam int CAP  = 15;

  logic clk = 1'b0, rstN = 1'b0, ps2Clk = 1'b1, ps2Dat = 1'b1, rdStrobe = 1'b0;
  logic codeValid, releaseFlag;
  logic [7:0] codeOut;

  kbd_code_rx #(.CLK_HZ(1_000_000), .IDLE_US(IDLE), .FILT_LEN(3), .DEPTH(16)) i_kbd_code_rx (
    .clk(clk), .rstN(rstN), .ps2Clk(ps2Clk), .ps2Dat(ps2Dat), .rdStrobe(rdStrobe),
    .codeValid(codeValid), .codeOut(codeOut), .releaseFlag(releaseFlag));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] q[$];
  bit rel = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic stripModel();
    while (q.size() >= 2 && q[0] == 8'hF0) begin
      void'(q.pop_front());
      rel = 1;
    end
  endtask

  function automatic bit expValid();
    return (q.size() != 0) && (q[0] != 8'hF0);
  endfunction

  task automatic modelPush(logic [7:0] b);
    if (q.size() < CAP) q.push_back(b);
    stripModel();
  endtask

  task automatic modelPop();
    void'(q.pop_front());
    rel = 0;
    stripModel();
  endtask

  // nBits < 11 sends a partial frame; rdOff >= 0 places one read pulse after the last edge
  task automatic sendFrame(logic [7:0] b, bit badPar, bit badStop, int nBits, int rdOff);
    logic [10:0] fr;
    fr = {~badStop, (~^b) ^ badPar, b, 1'b0};
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk) ps2Dat = fr[i];
      repeat (HALF) @(negedge clk);
      ps2Clk = 1'b0;
      for (int k = 0; k < HALF; k++) begin
        @(negedge clk);
        rdStrobe = (i == nBits - 1) && (k == rdOff);
      end
      rdStrobe = 1'b0;
      ps2Clk = 1'b1;
    end
    ps2Dat = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic compare(string req);
    @(negedge clk);
    check(req, codeValid, expValid());
    if (expValid()) check(req, codeOut, q[0]);
    check(req, releaseFlag, rel);
  endtask

  task automatic readOne(string req);
    compare(req);
    if (expValid()) begin
      rdStrobe = 1'b1;
      @(negedge clk) rdStrobe = 1'b0;
      modelPop();
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic sendCode(logic [7:0] b);
    sendFrame(b, 0, 0, 11, -1);
    modelPush(b);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (8) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 valid", codeValid, 0);
    check("R10 release", releaseFlag, 0);

    sendCode(8'h1C);
    readOne("R1 basic frame");
    compare("R1 empty after read");

    sendFrame(8'h33, 1, 0, 11, -1); modelPush(8'h33);
    sendFrame(8'h44, 0, 1, 11, -1); modelPush(8'h44);
    readOne("R2 bad parity");
    readOne("R2 low stop");

    sendCode(8'hF0);
    compare("R6 bare prefix");
    rdStrobe = 1'b1; @(negedge clk) rdStrobe = 1'b0;
    compare("R11 read ignored");
    sendCode(8'h2B);
    compare("R5 prefix stripped");
    readOne("R5 release read");
    compare("R7 flag cleared");
    sendCode(8'h29);
    readOne("R7 make after release");

    for (int i = 0; i < 17; i++) sendCode(8'(8'h40 + i));
    for (int i = 0; i < CAP; i++) readOne("R3 R4 full order");
    compare("R3 dropped extras");

    sendFrame(8'hFF, 0, 0, 4, -1);
    repeat (IDLE + 50) @(negedge clk);
    sendCode(8'h5A);
    readOne("R8 idle resync");

    for (int g = 0; g < 12; g++) begin
      @(negedge clk) ps2Clk = 1'b0;
      repeat (2) @(negedge clk);
      ps2Clk = 1'b1;
      repeat (6) @(negedge clk);
    end
    compare("R9 glitches ignored");
    sendCode(8'h6C);
    readOne("R9 frame after glitches");

    for (int off = 0; off < 16; off++) begin
      sendCode(8'(8'h60 + off));
      sendFrame(8'(8'hA0 + off), 0, 0, 11, off);
      modelPop();
      modelPush(8'(8'hA0 + off));
      compare("R12 read with write");
      readOne("R12 new code kept");
      compare("R12 empty");
    end

    for (int n = 0; n < 60; n++) begin
      logic [7:0] b;
      b = ($urandom % 4 == 0) ? 8'hF0 : 8'($urandom);
      sendCode(b);
      if ($urandom % 3 != 0) readOne("R4 R5 random");
      else compare("R4 R6 random");
    end
    while (expValid()) readOne("R4 drain");
    compare("R6 drained");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule